// File: doc/BRIEF.md
# Edge-Aligned PWM Timer with Shadowed Compare

A 16-bit up-counting timer that produces several edge-aligned pulse-width-modulated outputs. A power-of-two prescaler slows the count. The counter climbs from zero to a period limit, returns to zero and raises an update event. Each output channel compares the running count with its own threshold. It then turns the result into a pin level, using a per-channel comparison sense, an inversion bit and an enable.

The period limit and every threshold can be written directly into the active (shadow) copy. They can also be written into a holding (preload) copy that moves into the shadow copy only at the next update event, so a new duty cycle always starts on a period boundary. Comparing the count against the shadow values gives exact 0% and 100% duty at the extremes, with no one-cycle spike. A sticky update flag, gated by an enable, lets the surrounding logic step through external channel multiplexing once per period.

Top module: `pwm_timer_top`

## Requirements
- R1: While `rst` is high and one cycle after, `count` is 0, `upd_flag` is 0 and every `pwm_out` bit is 0.
- R2: With `cnt_en` high, `count` advances by one every 2^`psc_exp` clock cycles (exponent 0 to 15; exponent 3 gives one step per 8 cycles).
- R3: `count` runs from 0 up to the active period limit and at the following step returns to 0, which is the update event; one period lasts (limit+1)·2^`psc_exp` cycles.
- R4: With `cnt_en` low, both the prescaler and `count` hold their values.
- R5: In `ch_mode` bit value 0 the reference level is 1 while `count` < threshold and 0 otherwise; in value 1 it is 0 while `count` < threshold and 1 otherwise.
- R6: A threshold above the period limit gives a constant reference of 1 in mode 0, and a threshold of 0 gives a constant 0 in mode 0, with no pulse in either case.
- R7: A `ch_pol` bit of 1 inverts that channel's output relative to its reference.
- R8: A channel whose `ch_en` bit is 0 drives its inactive level, equal to its `ch_pol` bit.
- R9: With the matching preload bit set, a write reaches the holding copy only and has no effect on the outputs or on the wrap point until the next update event copies it into the active copy.
- R10: With the matching preload bit clear, a write replaces the active value at the next clock edge.
- R11: `upd_flag` is set at an update event when `upd_irq_en` is 1, never set while it is 0, and cleared by a one-cycle `upd_clr` pulse; a simultaneous set wins.
- R12: Each `pwm_out` bit is registered and reflects the `count` value of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counting enable |
| psc_exp | input | 4 | Prescaler exponent, divide by 2^psc_exp |
| arr_preload | input | 1 | Period limit goes through the holding copy |
| arr_wr | input | 1 | Write strobe for the period limit |
| cmp_preload | input | 3 | Per-channel threshold goes through the holding copy |
| cmp_wr | input | 3 | Per-channel threshold write strobe |
| wr_data | input | 16 | Value for any write strobe |
| ch_mode | input | 3 | Per-channel comparison sense (0: active below threshold) |
| ch_pol | input | 3 | Per-channel output inversion |
| ch_en | input | 3 | Per-channel output enable |
| upd_irq_en | input | 1 | Lets update events set the flag |
| upd_clr | input | 1 | Clears the update flag |
| pwm_out | output | 3 | Registered channel outputs |
| upd_flag | output | 1 | Sticky update-pending flag |
| count | output | 16 | Current counter value |

## Verification
A wrong shadow value shows as a wrong duty count over a whole period or as a wrap at the wrong count. It appears within one period of the update event that should have loaded it. A prescaler or counter fault moves `count` away from its cycle-exact expected value within a few prescaled steps. A comparison or lag fault shifts the falling edge of an output by one or more cycles, and a spike at threshold 0 adds a single high sample to a period that must stay at zero.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic {
    SENSE_HIGH_BELOW = 1'b0,
    SENSE_LOW_BELOW  = 1'b1
  } cmp_sense_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [EXP_W-1:0] psc_exp,
  output logic             tick
);
  localparam int DIV_W = 1 << EXP_W;

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] limit;

  assign limit = (DIV_W'(1) << psc_exp) - DIV_W'(1);
  assign tick  = run && (div_cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst)       div_cnt <= '0;
    else if (run)  div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
  end

  // R4: a stopped timer keeps its prescale phase
  p_psc_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(div_cnt));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             arr_preload,
  input  logic             arr_wr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] arr_hold;
  logic [CNT_W-1:0] arr_act;

  assign wrap = tick && (cnt >= arr_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_hold <= '0;
      arr_act  <= '0;
      cnt      <= '0;
    end else begin
      if (arr_wr) arr_hold <= wr_data;
      if (arr_wr && !arr_preload)  arr_act <= wr_data;
      else if (wrap && arr_preload) arr_act <= arr_wr ? wr_data : arr_hold;
      if (tick) cnt <= wrap ? '0 : cnt + CNT_W'(1);
    end
  end

  // R3: the update event restarts the count
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));
  // R3: a prescaled step without wrap adds exactly one
  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !wrap) |=> (cnt == $past(cnt) + CNT_W'(1)));
  // R4: no step without a prescaler tick
  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wrap,
  input  logic             preload,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             mode,
  input  logic             pol,
  input  logic             en,
  output logic             out
);
  import pwm_timer_pkg::*;

  logic [CNT_W-1:0] thr_hold;
  logic [CNT_W-1:0] thr_act;
  logic             below;
  logic             ref_lvl;

  assign below   = cnt < thr_act;
  assign ref_lvl = (cmp_sense_e'(mode) == SENSE_HIGH_BELOW) ? below : !below;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_hold <= '0;
      thr_act  <= '0;
      out      <= 1'b0;
    end else begin
      if (wr) thr_hold <= wr_data;
      if (wr && !preload)       thr_act <= wr_data;
      else if (wrap && preload) thr_act <= wr ? wr_data : thr_hold;
      out <= en ? (ref_lvl ^ pol) : pol;
    end
  end

  // R8: a disabled channel sits at its inactive level
  p_off_level_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (out == $past(pol)));
  // R6: threshold zero in mode 0 never produces an active sample
  p_zero_thr_r6: assert property (@(posedge clk) disable iff (rst)
    (en && !mode && thr_act == '0) |=> (out == $past(pol)));
endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top #(
  parameter int CNT_W = 16,
  parameter int EXP_W = 4,
  parameter int CH_N  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [EXP_W-1:0] psc_exp,
  input  logic             arr_preload,
  input  logic             arr_wr,
  input  logic [CH_N-1:0]  cmp_preload,
  input  logic [CH_N-1:0]  cmp_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CH_N-1:0]  ch_mode,
  input  logic [CH_N-1:0]  ch_pol,
  input  logic [CH_N-1:0]  ch_en,
  input  logic             upd_irq_en,
  input  logic             upd_clr,
  output logic [CH_N-1:0]  pwm_out,
  output logic             upd_flag,
  output logic [CNT_W-1:0] count
);
  logic tick;
  logic wrap;

  pwm_prescaler #(.EXP_W(EXP_W)) i_psc (
    .clk(clk), .rst(rst), .run(cnt_en), .psc_exp(psc_exp), .tick(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .tick(tick), .arr_preload(arr_preload),
    .arr_wr(arr_wr), .wr_data(wr_data), .cnt(count), .wrap(wrap)
  );

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) i_ch (
      .clk(clk), .rst(rst), .cnt(count), .wrap(wrap),
      .preload(cmp_preload[g]), .wr(cmp_wr[g]), .wr_data(wr_data),
      .mode(ch_mode[g]), .pol(ch_pol[g]), .en(ch_en[g]), .out(pwm_out[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                      upd_flag <= 1'b0;
    else if (wrap && upd_irq_en)  upd_flag <= 1'b1;
    else if (upd_clr)             upd_flag <= 1'b0;
  end

  // R11: the flag only rises after an enabled update event
  p_flag_src_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(upd_flag) |-> $past(wrap && upd_irq_en));
  // R11: a clear without a competing set empties the flag
  p_flag_clr_r11: assert property (@(posedge clk) disable iff (rst)
    (upd_clr && !(wrap && upd_irq_en)) |=> !upd_flag);
endmodule

// File: tb/test_pwm_timer_top.sv
module test_pwm_timer_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cnt_en;
  logic [3:0]  psc_exp;
  logic        arr_preload;
  logic        arr_wr;
  logic [2:0]  cmp_preload;
  logic [2:0]  cmp_wr;
  logic [15:0] wr_data;
  logic [2:0]  ch_mode;
  logic [2:0]  ch_pol;
  logic [2:0]  ch_en;
  logic        upd_irq_en;
  logic        upd_clr;
  logic [2:0]  pwm_out;
  logic        upd_flag;
  logic [15:0] count;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pwm_timer_top i_pwm_timer_top (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .psc_exp(psc_exp),
    .arr_preload(arr_preload), .arr_wr(arr_wr), .cmp_preload(cmp_preload),
    .cmp_wr(cmp_wr), .wr_data(wr_data), .ch_mode(ch_mode), .ch_pol(ch_pol),
    .ch_en(ch_en), .upd_irq_en(upd_irq_en), .upd_clr(upd_clr),
    .pwm_out(pwm_out), .upd_flag(upd_flag), .count(count)
  );

  typedef struct packed {
    logic [15:0] arr;
    logic [15:0] thr;
    logic        mode;
    logic        pol;
    logic [3:0]  ex;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{arr: 16'd9,   thr: 16'd3,   mode: 1'b0, pol: 1'b0, ex: 4'd0},
    '{arr: 16'd9,   thr: 16'd3,   mode: 1'b1, pol: 1'b0, ex: 4'd0},
    '{arr: 16'd9,   thr: 16'd0,   mode: 1'b0, pol: 1'b0, ex: 4'd0},
    '{arr: 16'd9,   thr: 16'd10,  mode: 1'b0, pol: 1'b0, ex: 4'd0},
    '{arr: 16'd9,   thr: 16'd200, mode: 1'b1, pol: 1'b0, ex: 4'd0},
    '{arr: 16'd9,   thr: 16'd0,   mode: 1'b1, pol: 1'b1, ex: 4'd0},
    '{arr: 16'd255, thr: 16'd64,  mode: 1'b0, pol: 1'b1, ex: 4'd0},
    '{arr: 16'd15,  thr: 16'd5,   mode: 1'b0, pol: 1'b0, ex: 4'd2}
  };

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic tick_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cnt_en = 1'b0; psc_exp = '0; arr_preload = 1'b0;
    arr_wr = 1'b0; cmp_preload = '0; cmp_wr = '0; wr_data = '0;
    ch_mode = '0; ch_pol = '0; ch_en = '0; upd_irq_en = 1'b0; upd_clr = 1'b0;
    tick_n(2);
    rst = 1'b0;
  endtask

  task automatic wr_arr(input logic [15:0] v);
    wr_data = v; arr_wr = 1'b1; tick_n(1); arr_wr = 1'b0;
  endtask

  task automatic wr_thr(input int ch, input logic [15:0] v);
    wr_data = v; cmp_wr[ch] = 1'b1; tick_n(1); cmp_wr = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    rst = 1'b1;
    tick_n(1);
    chk("R1 count", count, 0);
    chk("R1 flag", upd_flag, 0);
    chk("R1 outputs", pwm_out, 0);
    rst = 1'b0;

    // R5 R6 R7 R8: duty over one full period, table driven
    for (int i = 0; i < 8; i++) begin
      automatic vec_t v = VECS[i];
      automatic int ch = i % 3;
      automatic int per = (int'(v.arr) + 1) << v.ex;
      automatic int ref_hi = (v.thr > v.arr) ? int'(v.arr) + 1 : int'(v.thr);
      automatic int hi;
      automatic int seen = 0;
      if (v.mode) ref_hi = int'(v.arr) + 1 - ref_hi;
      hi = v.pol ? (int'(v.arr) + 1 - ref_hi) : ref_hi;
      hi = hi << v.ex;
      do_reset();
      psc_exp = v.ex;
      wr_arr(v.arr);
      wr_thr(ch, v.thr);
      ch_mode = {3{v.mode}};
      ch_pol  = {3{v.pol}};
      ch_en   = 3'b001 << ch;
      cnt_en  = 1'b1;
      tick_n(2 * per);
      for (int k = 0; k < per; k++) begin
        if (pwm_out[ch]) seen++;
        tick_n(1);
      end
      chk($sformatf("R5/R6/R7 duty vec %0d", i), seen, hi);
      chk($sformatf("R8 idle level vec %0d", i), pwm_out[(ch + 1) % 3], v.pol);
    end

    // R2 R4: prescaler rate and hold
    do_reset();
    psc_exp = 4'd3;
    wr_arr(16'd1000);
    cnt_en = 1'b1;
    tick_n(40);
    chk("R2 count after 40 cycles at /8", count, 5);
    cnt_en = 1'b0;
    tick_n(20);
    chk("R4 count held", count, 5);
    cnt_en = 1'b1;
    tick_n(8);
    chk("R4 prescale phase kept", count, 6);

    // R9 R10 R3: period limit through holding copy and direct
    do_reset();
    wr_arr(16'd9);
    arr_preload = 1'b1;
    cnt_en = 1'b1;
    tick_n(3);
    chk("R3 count 3", count, 3);
    wr_arr(16'd99);
    tick_n(6);
    chk("R9 wrap at old limit", count, 0);
    tick_n(30);
    chk("R9 new limit active", count, 30);
    arr_preload = 1'b0;
    wr_arr(16'd40);
    tick_n(9);
    chk("R10 count 40", count, 40);
    tick_n(1);
    chk("R10 wrap at direct limit", count, 0);

    // R11: update flag
    do_reset();
    wr_arr(16'd4);
    upd_irq_en = 1'b1;
    cnt_en = 1'b1;
    tick_n(4);
    chk("R11 flag before update", upd_flag, 0);
    tick_n(2);
    chk("R11 flag after update", upd_flag, 1);
    upd_clr = 1'b1; tick_n(1); upd_clr = 1'b0;
    chk("R11 flag cleared", upd_flag, 0);
    upd_irq_en = 1'b0;
    tick_n(12);
    chk("R11 flag gated off", upd_flag, 0);

    // R9: threshold write held until the update event
    do_reset();
    wr_arr(16'd9);
    ch_en = 3'b001;
    cmp_preload = 3'b001;
    wr_thr(0, 16'd50);
    tick_n(5);
    chk("R9 held threshold no effect", pwm_out[0], 0);
    cnt_en = 1'b1;
    tick_n(5);
    chk("R9 before update", pwm_out[0], 0);
    tick_n(10);
    chk("R9 after update full duty", pwm_out[0], 1);

    // R12: output lags count by one cycle
    do_reset();
    wr_arr(16'd9);
    wr_thr(1, 16'd3);
    ch_en = 3'b010;
    cnt_en = 1'b1;
    tick_n(3);
    chk("R12 count 3", count, 3);
    chk("R12 out still high", pwm_out[1], 1);
    tick_n(1);
    chk("R12 out low one cycle later", pwm_out[1], 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule